// File: doc/BRIEF.md
# SIMD Chunk Permute and Select Unit

This execution unit rearranges the chunks of a source word. The chunk width is chosen per operation as 8, 16, 32 or 64 bits. One bank of byte-wide multiplexers does all of the work. Every result byte has a select index that picks one source byte, and an enable that forces the byte to zero when it is low. The fixed patterns (reversal and duplication) and the data-driven patterns (where the select indices come from a selector operand or from an immediate) all drive the same select lines. Because of this, data-driven selection uses the same mux depth and the same latency as a fixed reversal.

The result is registered once. An operation is presented with `in_valid`. Its result appears on `result` with `out_valid` one clock later, and the result holds while no new operation arrives. A 64-bit data path is the default. The width is a parameter, and it must be a power of two between 64 and 2048 bits so that the index for 8-bit chunks always fits in the low bits of one selector chunk.

Top module: `chunk_shuffle_unit`

## Requirements
- R1: `size` sets the chunk width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. The word holds DATA_W divided by that width chunks, numbered from 0 at the least significant end.
- R2: For op code 0 (permute), result chunk i is source chunk k. The value k is read from the low bits of chunk i of `src_sel`.
- R3: Only the low log2(number of chunks) bits of a selector chunk, or of the immediate, are used. All higher bits have no effect on the result.
- R4: For op code 1 (select), source chunk k goes into result chunk 0, where k comes from chunk 0 of `src_sel`. All other result bits are zero.
- R5: Op code 2 (select immediate) works like select, except that k comes from the low bits of the 8-bit unsigned `imm`.
- R6: Duplication works in two ways. Permute with an all-zero selector copies source chunk 0 into every result chunk. Op code 5 copies source chunk n into every result chunk, where n is taken from `imm`.
- R7: Op code 3 (SIMD reverse) places source chunk (N-1-i) into result chunk i, where N is the number of chunks.
- R8: Op code 4 (scalar reverse) reverses the byte order of the low chunk only. The reversed chunk goes in the low chunk and every higher bit is zero.
- R9: Op codes 6 and 7 give an all-zero result.
- R10: `out_valid` is high exactly one clock after `in_valid` was high, and low otherwise. An active-low synchronous reset clears `out_valid`. `result` keeps its value in cycles with no new operation.
- R11: With 64-bit chunks there is only one chunk, so permute, select, select immediate, duplicate and SIMD reverse all return `src_a` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code (see R2 to R9) |
| size | input | 2 | Chunk width code (R1) |
| src_a | input | DATA_W | Source word whose chunks are moved |
| src_sel | input | DATA_W | Selector word, one index per chunk |
| imm | input | 8 | Unsigned immediate chunk index |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| result | output | DATA_W | Registered result word |

## Verification
Every result is due on the first rising edge after the cycle in which `in_valid` was high, since one register sits between the mux bank and `result`. The bench drives each operation on a falling edge. It then waits for the next falling edge, which is half a period after that capture edge, and compares `result` and `out_valid` there. The idle and hold checks follow the same rule: one clock after `in_valid` is lowered, `out_valid` must be low and `result` must be unchanged.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

   localparam logic [2:0] OP_PERM = 3'd0;
   localparam logic [2:0] OP_SEL  = 3'd1;
   localparam logic [2:0] OP_SELI = 3'd2;
   localparam logic [2:0] OP_REV  = 3'd3;
   localparam logic [2:0] OP_SREV = 3'd4;
   localparam logic [2:0] OP_DUPN = 3'd5;

   // log2 of the chunk width in bytes for a given size code
   function automatic int chunk_shift(input logic [1:0] size_code);
      return int'(size_code);
   endfunction

endpackage

// File: rtl/shuf_route.sv
module shuf_route
   import shuf_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [2:0]                                   op,
   input  logic [1:0]                                   size,
   input  logic [DATA_W-1:0]                            sel_word,
   input  logic [7:0]                                   imm,
   output logic [DATA_W/8-1:0][$clog2(DATA_W/8)-1:0]    src_idx,
   output logic [DATA_W/8-1:0]                          lane_en
);

   localparam int NB = DATA_W / 8;
   localparam int IW = $clog2(NB);

   for (genvar b = 0; b < NB; b++) begin : g_lane
      logic          en_l;
      logic [IW-1:0] idx_l;

      always_comb begin
         int         sh;
         int         cb;
         int         nc;
         int         ci;
         int         wi;
         int         kk;
         int         srcb;
         logic [7:0] selb;
         sh   = chunk_shift(size);
         cb   = 1 << sh;
         nc   = NB >> sh;
         ci   = b >> sh;
         wi   = b & (cb - 1);
         selb = sel_word[(ci << sh) * 8 +: 8];
         kk   = 0;
         en_l = 1'b0;
         case (op)
            OP_PERM: begin
               kk   = int'(selb) & (nc - 1);
               en_l = 1'b1;
            end
            OP_SEL: begin
               kk   = int'(sel_word[7:0]) & (nc - 1);
               en_l = (ci == 0);
            end
            OP_SELI: begin
               kk   = int'(imm) & (nc - 1);
               en_l = (ci == 0);
            end
            OP_REV: begin
               kk   = nc - 1 - ci;
               en_l = 1'b1;
            end
            OP_SREV: begin
               kk   = 0;
               en_l = (ci == 0);
            end
            OP_DUPN: begin
               kk   = int'(imm) & (nc - 1);
               en_l = 1'b1;
            end
            default: begin
               kk   = 0;
               en_l = 1'b0;
            end
         endcase
         if (op == OP_SREV) srcb = cb - 1 - wi;
         else               srcb = (kk << sh) | wi;
         idx_l = IW'(srcb);
      end

      assign src_idx[b] = idx_l;
      assign lane_en[b] = en_l;
   end

endmodule

// File: rtl/shuf_mux.sv
module shuf_mux #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]                            src,
   input  logic [DATA_W/8-1:0][$clog2(DATA_W/8)-1:0]    src_idx,
   input  logic [DATA_W/8-1:0]                          lane_en,
   output logic [DATA_W-1:0]                            dst
);

   localparam int NB = DATA_W / 8;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign dst[b*8 +: 8] = lane_en[b] ? src[int'(src_idx[b]) * 8 +: 8] : 8'h00;
   end

endmodule

// File: rtl/chunk_shuffle_unit.sv
module chunk_shuffle_unit
   import shuf_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op,
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_sel,
   input  logic [7:0]        imm,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);

   localparam int NB = DATA_W / 8;
   localparam int IW = $clog2(NB);

   if ((DATA_W % 64) != 0 || (DATA_W & (DATA_W - 1)) != 0 || DATA_W > 2048) begin : g_bad_width
      $error("chunk_shuffle_unit: DATA_W must be a power of two from 64 to 2048");
   end

   logic [NB-1:0][IW-1:0] idx;
   logic [NB-1:0]         en;
   logic [DATA_W-1:0]     shuffled;

   shuf_route #(.DATA_W(DATA_W)) u_route (
      .op       (op),
      .size     (size),
      .sel_word (src_sel),
      .imm      (imm),
      .src_idx  (idx),
      .lane_en  (en)
   );

   shuf_mux #(.DATA_W(DATA_W)) u_mux (
      .src     (src_a),
      .src_idx (idx),
      .lane_en (en),
      .dst     (shuffled)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) result <= shuffled;
   end

   // R10: strobe latency of one clock
   assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   // R4 R5: select modes leave everything above the low chunk zero
   assert_select_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (op == OP_SEL || op == OP_SELI)
      |=> (result >> (8 << $past(size))) == '0);

   // R9: unused codes give zero
   assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (op > OP_DUPN) |=> result == '0);

   // R6: zero selector duplicates byte 0 everywhere
   assert_zero_sel_dup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == OP_PERM && size == 2'd0 && src_sel == '0
      |=> result == {NB{$past(src_a[7:0])}});

endmodule

// File: tb/tb_chunk_shuffle_unit.sv
module tb_chunk_shuffle_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [2:0]  op;
   logic [1:0]  size;
   logic [63:0] src_a;
   logic [63:0] src_sel;
   logic [7:0]  imm;
   logic        out_valid;
   logic [63:0] result;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chunk_shuffle_unit #(.DATA_W(64)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
      .src_a(src_a), .src_sel(src_sel), .imm(imm),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] ref_model(input logic [2:0] o, input logic [1:0] s,
                                             input logic [63:0] a, input logic [63:0] sl,
                                             input logic [7:0] im);
      int cw = 8 << s;
      int nc = 64 / cw;
      logic [63:0] m = (cw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << cw) - 64'd1);
      logic [63:0] r = '0;
      int k;
      case (o)
         3'd0: for (int i = 0; i < nc; i++) begin
                  k = int'((sl >> (i*cw)) & 64'hFF) & (nc - 1);
                  r |= ((a >> (k*cw)) & m) << (i*cw);
               end
         3'd1: begin k = int'(sl[7:0]) & (nc - 1); r = (a >> (k*cw)) & m; end
         3'd2: begin k = int'(im) & (nc - 1);     r = (a >> (k*cw)) & m; end
         3'd3: for (int i = 0; i < nc; i++)
                  r |= ((a >> ((nc-1-i)*cw)) & m) << (i*cw);
         3'd4: for (int j = 0; j < cw/8; j++)
                  r[j*8 +: 8] = a[(cw/8-1-j)*8 +: 8];
         3'd5: begin
                  k = int'(im) & (nc - 1);
                  for (int i = 0; i < nc; i++) r |= ((a >> (k*cw)) & m) << (i*cw);
               end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive on a falling edge, capture at the next rising edge, sample at the following falling edge
   task automatic run_op(input string req, input logic [2:0] o, input logic [1:0] s,
                         input logic [63:0] a, input logic [63:0] sl, input logic [7:0] im,
                         input logic [63:0] exp);
      op = o; size = s; src_a = a; src_sel = sl; imm = im; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, {63'd0, out_valid}, 64'd1);
      check(req, result, exp);
   endtask

   task automatic run_model(input string req, input logic [2:0] o, input logic [1:0] s,
                            input logic [63:0] a, input logic [63:0] sl, input logic [7:0] im);
      run_op(req, o, s, a, sl, im, ref_model(o, s, a, sl, im));
   endtask

   localparam logic [63:0] SEQ = 64'h0807_0605_0403_0201;

   task automatic test_reset();
      rst_n = 1'b0; in_valid = 1'b0;
      op = '0; size = '0; src_a = '0; src_sel = '0; imm = '0;
      repeat (3) @(negedge clk);
      check("R10 reset", {63'd0, out_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after reset", {63'd0, out_valid}, 64'd0);
   endtask

   task automatic test_permute();
      run_op("R2 byte permute", 3'd0, 2'd0, SEQ, 64'h0001_0203_0405_0607, 8'd0, 64'h0102_0304_0506_0708);
      run_op("R2 halfword permute", 3'd0, 2'd1, SEQ, 64'h0000_0002_0001_0003, 8'd0, 64'h0201_0605_0403_0807);
      for (int s = 0; s < 3; s++)
         run_model("R2 permute pattern", 3'd0, 2'(s), 64'hDEAD_BEEF_0123_4567, 64'h0306_0102_0704_0005, 8'd0);
      run_model("R1 size code 2 chunks", 3'd0, 2'd2, 64'h1111_2222_3333_4444, 64'h0000_0000_0000_0001, 8'd0);
   endtask

   task automatic test_highbits();
      run_op("R3 selector high bits ignored", 3'd0, 2'd0, SEQ, 64'hF8F9_FAFB_FCFD_FEFF, 8'd0, 64'h0102_0304_0506_0708);
      run_op("R3 imm high bits ignored", 3'd2, 2'd1, SEQ, '0, 8'hFE, 64'h0000_0000_0000_0605);
   endtask

   task automatic test_select();
      run_op("R4 select word", 3'd1, 2'd2, SEQ, 64'h0000_0000_0000_0001, 8'd0, 64'h0000_0000_0807_0605);
      run_op("R4 select byte", 3'd1, 2'd0, SEQ, 64'h0000_0000_0000_0005, 8'd0, 64'h0000_0000_0000_0006);
   endtask

   task automatic test_seli();
      run_op("R5 select imm byte", 3'd2, 2'd0, SEQ, 64'hFFFF_FFFF_FFFF_FFFF, 8'd7, 64'h0000_0000_0000_0008);
      run_model("R5 select imm half", 3'd2, 2'd1, 64'hA1A2_B1B2_C1C2_D1D2, '0, 8'd2);
   endtask

   task automatic test_dup();
      run_op("R6 zero selector dup", 3'd0, 2'd0, SEQ, '0, 8'd0, 64'h0101_0101_0101_0101);
      run_op("R6 dup-n half", 3'd5, 2'd1, SEQ, '0, 8'd3, 64'h0807_0807_0807_0807);
      run_model("R6 dup-n byte", 3'd5, 2'd0, SEQ, '0, 8'd10);
   endtask

   task automatic test_rev();
      run_op("R7 SIMD reverse bytes", 3'd3, 2'd0, SEQ, '0, 8'd0, 64'h0102_0304_0506_0708);
      run_op("R7 SIMD reverse halves", 3'd3, 2'd1, SEQ, '0, 8'd0, 64'h0201_0403_0605_0807);
      run_op("R7 SIMD reverse words", 3'd3, 2'd2, SEQ, '0, 8'd0, 64'h0403_0201_0807_0605);
   endtask

   task automatic test_srev();
      run_op("R8 scalar reverse half", 3'd4, 2'd1, SEQ, '0, 8'd0, 64'h0000_0000_0000_0102);
      run_op("R8 scalar reverse word", 3'd4, 2'd2, SEQ, '0, 8'd0, 64'h0000_0000_0102_0304);
      run_op("R8 scalar reverse byte", 3'd4, 2'd0, SEQ, '0, 8'd0, 64'h0000_0000_0000_0001);
      run_op("R8 scalar reverse dword", 3'd4, 2'd3, SEQ, '0, 8'd0, 64'h0102_0304_0506_0708);
   endtask

   task automatic test_unused();
      run_op("R9 op code 6", 3'd6, 2'd0, SEQ, 64'h0102_0304_0506_0708, 8'd3, 64'd0);
      run_op("R9 op code 7", 3'd7, 2'd2, SEQ, '1, 8'd1, 64'd0);
   endtask

   task automatic test_wide();
      for (int o = 0; o < 6; o++)
         if (o != 4)
            run_op("R11 single chunk passthrough", 3'(o), 2'd3, 64'hCAFE_F00D_1234_5678,
                   64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 64'hCAFE_F00D_1234_5678);
   endtask

   task automatic test_timing();
      logic [63:0] held;
      run_op("R10 strobe", 3'd3, 2'd0, SEQ, '0, 8'd0, 64'h0102_0304_0506_0708);
      held = result;
      op = 3'd0; src_a = '1; src_sel = '0;
      @(negedge clk);
      check("R10 no strobe", {63'd0, out_valid}, 64'd0);
      check("R10 result held", result, held);
      @(negedge clk);
      check("R10 still held", result, held);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      test_reset();
      test_permute();
      test_highbits();
      test_select();
      test_seli();
      test_dup();
      test_rev();
      test_srev();
      test_unused();
      test_wide();
      test_timing();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule